// File: doc/BRIEF.md
# Externally Clocked PWM Timer

This block is one general-purpose timer channel that drives a pulse-width-modulated pin. A single system clock runs all of its logic. A select input picks where count events come from. With the select clear, every system clock cycle is a count event. With the select set, a count event is each rising edge of an asynchronous external clock. That clock is first synchronised into the system domain, and its rising edges are then detected there. A mode input picks between a waveform that repeats without end and a single pulse whose length is the programmed width.

Period and width are taken as inputs and held in shadow copies. While the timer is disabled, the shadow copies follow the inputs. Once the timer runs, new values are taken up only at a period boundary, so a change never cuts into the period in progress. An interrupt pulse marks the end of each period in repeating mode and the end of the pulse in single-pulse mode. Software can write the next period and width as soon as it sees that interrupt.

Top module: `ext_pwm_timer`

## Requirements
- R1: With `clk_sel`=0, the counter advances on every system clock cycle while `en`=1.
- R2: With `clk_sel`=1, the counter starts at zero when enabled and advances once per rising edge of `ext_clk`. Falling edges of `ext_clk` never advance the counter.
- R3: `tmr_out` changes only on a cycle that follows a count event, so in external mode it is aligned to `ext_clk` rising edges.
- R4: `pol_high`=1 makes the active level high and `pol_high`=0 makes it low. The timing is the same for both settings.
- R5: In repeating mode the counter runs 1..P and then reloads to 1, giving exactly P count events per period. A period input of 0 is treated as 1.
- R6: In repeating mode (`cont_mode`=1), `tmr_out` is active while the count lies in 1..W and inactive for the rest of the period.
- R7: A width of 0 keeps the output inactive for the whole period. A width of at least P keeps it active for the whole period.
- R8: In single-pulse mode (`cont_mode`=0), the output is active for exactly W count events. It then goes inactive, raises one interrupt, and stays idle until disabled.
- R9: `irq` is a single-cycle pulse. It is issued on the same clock edge as the count event that ends a period or a single pulse.
- R10: A new period or width presented while running takes effect from the next period boundary. The period in progress completes with the old values.
- R11: Clearing `en` forces `tmr_out` to its inactive level without waiting for a clock edge. It also clears the counter and the synchroniser state, so re-enabling starts from zero.
- R12: An `ext_clk` level held for at least one system clock period is seen. The counter takes a rising edge on the third system clock edge after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, applied synchronously |
| en | input | 1 | Timer enable |
| clk_sel | input | 1 | 0: count system cycles; 1: count external rising edges |
| cont_mode | input | 1 | 1: repeating waveform; 0: single pulse |
| pol_high | input | 1 | 1: active level high; 0: active level low |
| period_in | input | CW | Period in count events |
| width_in | input | CW | Active width in count events |
| ext_clk | input | 1 | Asynchronous external count clock |
| tmr_out | output | 1 | Timer pin |
| irq | output | 1 | Period-end or pulse-end interrupt strobe |

## Verification
A counter that wraps to zero, or wraps one count late, makes the pin waveform drift. It also moves the interrupt by a cycle within the first period, and the per-cycle pin comparison exposes both at once. If the shadow copies are taken up at the wrong time, the period in progress changes length, and that shows on the first boundary after the write. A broken edge detector shows in external mode within one `ext_clk` cycle, either as a count on a falling edge or as a missed rising edge. A slow enable-off path shows the moment `en` falls, because the pin is checked before the next clock edge.

// File: rtl/ept_pkg.sv
package ept_pkg;

  // A period of zero behaves as one count event
  function automatic logic [31:0] eff_period(input logic [31:0] p);
    return (p == 32'd0) ? 32'd1 : p;
  endfunction

  // Output is active for count values 1..width
  function automatic logic in_pulse(input logic [31:0] cnt, input logic [31:0] width);
    return (cnt != 32'd0) && (cnt <= width);
  endfunction

  // Repeating mode reaches its period boundary at the last count
  function automatic logic at_wrap(input logic [31:0] cnt, input logic [31:0] period);
    return (cnt != 32'd0) && (cnt == eff_period(period));
  endfunction

  // Single-pulse mode ends once the width has been counted out
  function automatic logic at_shot_end(input logic [31:0] cnt, input logic [31:0] width);
    return cnt >= width;
  endfunction

endpackage

// File: rtl/ept_edge_sync.sv
module ept_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic ext_clk,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n || clr) sh[0] <= 1'b0;
          else               sh[0] <= ext_clk;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n || clr) sh[i] <= 1'b0;
          else               sh[i] <= sh[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n || clr) prev <= 1'b0;
    else               prev <= sh[STAGES-1];
  end

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/ept_shadow.sv
module ept_shadow #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] per_in,
  input  logic [CW-1:0] wid_in,
  output logic [CW-1:0] per_act,
  output logic [CW-1:0] wid_act,
  output logic [CW-1:0] per_nxt,
  output logic [CW-1:0] wid_nxt
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_act <= '0;
      wid_act <= '0;
    end else if (load) begin
      per_act <= per_in;
      wid_act <= wid_in;
    end
  end

  // Values that govern the cycle after this edge
  assign per_nxt = load ? per_in : per_act;
  assign wid_nxt = load ? wid_in : wid_act;
endmodule

// File: rtl/ept_core.sv
module ept_core
  import ept_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          tick,
  input  logic          cont,
  input  logic [CW-1:0] per_act,
  input  logic [CW-1:0] wid_act,
  input  logic [CW-1:0] wid_nxt,
  output logic          wrap,
  output logic [CW-1:0] cnt_q,
  output logic          act_q,
  output logic          done_q,
  output logic          irq_q
);
  logic [CW-1:0] cnt_n;
  logic          act_n, done_n, irq_n, shot_end;

  assign wrap     = cont && at_wrap(32'(cnt_q), 32'(per_act));
  assign shot_end = !cont && at_shot_end(32'(cnt_q), 32'(wid_act));

  always_comb begin
    cnt_n  = cnt_q;
    act_n  = act_q;
    done_n = done_q;
    irq_n  = 1'b0;
    if (tick && !done_q) begin
      if (cont) begin
        cnt_n = wrap ? CW'(1) : cnt_q + CW'(1);
        irq_n = wrap;
        act_n = in_pulse(32'(cnt_n), 32'(wid_nxt));
      end else if (shot_end) begin
        done_n = 1'b1;
        act_n  = 1'b0;
        irq_n  = 1'b1;
      end else begin
        cnt_n = cnt_q + CW'(1);
        act_n = in_pulse(32'(cnt_n), 32'(wid_act));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      act_q  <= act_n;
      done_q <= done_n;
      irq_q  <= irq_n;
    end
  end
endmodule

// File: rtl/ext_pwm_timer.sv
module ext_pwm_timer #(
  parameter int CW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          clk_sel,
  input  logic          cont_mode,
  input  logic          pol_high,
  input  logic [CW-1:0] period_in,
  input  logic [CW-1:0] width_in,
  input  logic          ext_clk,
  output logic          tmr_out,
  output logic          irq
);
  logic          ext_rise, tick, wrap, load;
  logic          act_q, done_q;
  logic [CW-1:0] cnt_q, per_act, wid_act, per_nxt, wid_nxt;

  ept_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(!en), .ext_clk(ext_clk), .rise(ext_rise)
  );

  assign tick = clk_sel ? ext_rise : 1'b1;
  assign load = !en || (tick && wrap);

  ept_shadow #(.CW(CW)) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(load),
    .per_in(period_in), .wid_in(width_in),
    .per_act(per_act), .wid_act(wid_act),
    .per_nxt(per_nxt), .wid_nxt(wid_nxt)
  );

  ept_core #(.CW(CW)) u_core (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .cont(cont_mode),
    .per_act(per_act), .wid_act(wid_act), .wid_nxt(wid_nxt),
    .wrap(wrap), .cnt_q(cnt_q), .act_q(act_q), .done_q(done_q), .irq_q(irq)
  );

  logic lvl;
  assign lvl     = en & act_q;
  assign tmr_out = pol_high ? lvl : ~lvl;
endmodule

// File: rtl/ept_checker.sv
module ept_checker #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          pol_high,
  input logic          tick,
  input logic          ext_rise,
  input logic          wrap,
  input logic          done_q,
  input logic          act_q,
  input logic [CW-1:0] cnt_q,
  input logic          irq,
  input logic          tmr_out
);
  AST_EDGE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rise |=> !ext_rise); // R2

  AST_PIN_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && (act_q != $past(act_q))) |-> $past(tick)); // R3

  AST_WRAP_TO_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && $past(tick) && $past(wrap) && !$past(done_q)) |-> (cnt_q == CW'(1))); // R5

  AST_IRQ_FROM_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick)); // R9

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!en) |-> (cnt_q == '0 && !irq)); // R11

  AST_OFF_PIN: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (tmr_out == !pol_high)); // R11
endmodule

bind ext_pwm_timer ept_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pol_high(pol_high), .tick(tick),
  .ext_rise(ext_rise), .wrap(wrap), .done_q(done_q), .act_q(act_q),
  .cnt_q(cnt_q), .irq(irq), .tmr_out(tmr_out)
);

// File: tb/ext_pwm_timer_test.sv
module ext_pwm_timer_test;
  localparam int CW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, clk_sel = 1'b0, cont_mode = 1'b1, pol_high = 1'b1, ext_clk = 1'b0;
  logic [CW-1:0] period_in = '0, width_in = '0;
  logic tmr_out, irq;

  always #10 clk = ~clk;

  ext_pwm_timer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .clk_sel(clk_sel), .cont_mode(cont_mode),
    .pol_high(pol_high), .period_in(period_in), .width_in(width_in),
    .ext_clk(ext_clk), .tmr_out(tmr_out), .irq(irq)
  );

  int total = 0, bad = 0;
  int m_cnt, m_p, m_w;
  bit m_done, m_act, m_irq;

  function automatic int effp(int p);
    return (p == 0) ? 1 : p;
  endfunction

  task automatic chk(string req, logic got, logic exp, string what);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic chk_pins(string req);
    chk(req, tmr_out, pol_high ? m_act : !m_act, "tmr_out");
    chk(req, irq, m_irq, "irq");
  endtask

  task automatic m_load();
    m_p = effp(int'(period_in)); m_w = int'(width_in);
    m_cnt = 0; m_done = 0; m_act = 0; m_irq = 0;
  endtask

  task automatic m_tick();
    m_irq = 0;
    if (m_done) return;
    if (cont_mode) begin
      if (m_cnt == m_p) begin
        m_cnt = 1; m_irq = 1;
        m_p = effp(int'(period_in)); m_w = int'(width_in);
      end else m_cnt++;
      m_act = (m_cnt <= m_w);
    end else if (m_cnt >= m_w) begin
      m_done = 1; m_act = 0; m_irq = 1;
    end else begin
      m_cnt++; m_act = 1;
    end
  endtask

  task automatic start(int p, int w, bit cont, bit pol, bit sel);
    @(negedge clk);
    en = 0; ext_clk = 0;
    period_in = CW'(p); width_in = CW'(w);
    cont_mode = cont; pol_high = pol; clk_sel = sel;
    @(negedge clk);
    m_load();
    en = 1;
  endtask

  task automatic run_int(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      m_tick();
      chk_pins(req);
    end
  endtask

  task automatic ext_cycle(string req);
    @(negedge clk); ext_clk = 1;
    m_irq = 0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk_pins({req, " R12 before edge counts"});
    end
    @(negedge clk);
    m_tick();
    chk_pins({req, " R3 on edge"});
    ext_clk = 0;
    m_irq = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk_pins({req, " R2 falling edge ignored"});
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    m_load();
    chk_pins("R11 reset");
    rst_n = 1;
    @(negedge clk);
    chk_pins("R11 reset release");
  endtask

  task automatic t_cont();
    start(4, 2, 1, 1, 0);
    run_int(12, "R1 R5 R6 R9 cont P4 W2");
  endtask

  task automatic t_pol();
    start(5, 3, 1, 0, 0);
    run_int(10, "R4 low polarity");
  endtask

  task automatic t_corners();
    start(3, 0, 1, 1, 0);
    run_int(7, "R7 width zero");
    start(3, 7, 1, 1, 0);
    run_int(7, "R7 width over period");
    start(0, 1, 1, 1, 0);
    run_int(4, "R5 period zero as one");
  endtask

  task automatic t_update();
    start(4, 1, 1, 1, 0);
    run_int(2, "R10 before write");
    period_in = CW'(6); width_in = CW'(5);
    run_int(14, "R10 after write");
  endtask

  task automatic t_oneshot();
    start(9, 3, 0, 1, 0);
    run_int(10, "R8 single pulse W3");
    start(9, 0, 0, 1, 0);
    run_int(4, "R8 single pulse W0");
  endtask

  task automatic t_ext();
    start(3, 2, 1, 1, 1);
    @(negedge clk);
    chk_pins("R2 ext idle start");
    for (int i = 0; i < 7; i++) ext_cycle("R2 ext P3 W2");
    start(5, 2, 0, 0, 1);
    for (int i = 0; i < 4; i++) ext_cycle("R8 ext single pulse");
  endtask

  task automatic t_disable();
    start(5, 4, 1, 1, 0);
    run_int(3, "R11 pre-disable");
    en = 0;
    #1;
    chk("R11", tmr_out, 1'b0, "pin forced inactive at once");
    @(negedge clk);
    m_load(); m_irq = 0;
    chk_pins("R11 held off");
    en = 1;
    run_int(6, "R11 restart from zero");
  endtask

  bit wd_hit = 0;
  initial begin
    #(20 * 200000);
    wd_hit = 1;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_cont();
    t_pol();
    t_corners();
    t_update();
    t_oneshot();
    t_ext();
    t_disable();
    if (!wd_hit) begin
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule